// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block turns a virtual page into a real page by walking a hashed page table held in main memory. A caller presents a 24-bit segment identifier and a 32-bit effective address and pulses a start strobe. The engine hashes the segment identifier with the page index, folds the result into a table base and mask held in its own configuration register, and reads the entries of the selected 64-byte group one by one through a 64-bit read port.

If no entry of the first group matches, the engine complements the hash, selects a second group and searches it for entries tagged as secondary. The first match ends the walk and yields the real address, the four storage-control bits and the two protection bits. If both groups miss, the walk ends with a page-fault indication. Updating the reference and change bits is left to other logic.

Bit numbers below use the usual SystemVerilog convention (bit 0 is the least significant bit).

Top module: `hpt_walker`

## Requirements
- R1: After a synchronous active-low reset, busy, done, hit, fault and mem_req are 0, real_addr, wimg and prot are 0, and the configuration register is 0.
- R2: A cycle with cfg_load high and busy low stores cfg_data: bits 31:16 are the table base and bits 8:0 the hash mask, other bits are ignored. A cfg_load while busy is ignored and the running and later walks keep the previous value.
- R3: With V = vsid_in and E = ea_in, the primary hash is N = V[18:0] XOR {3'b000, E[27:12]}. The group address is {cfg[31:25], (N[18:10] AND cfg[8:0]) OR cfg[24:16], N[9:0], 6'b000000}.
- R4: Entries of a group are read in order 0 to 7 at group address + 8 x index. Each read is a one-cycle mem_req pulse with mem_addr, at most one read is outstanding, and the engine waits any number of cycles for the matching mem_valid.
- R5: mem_data[63:32] is entry word 0: valid in bit 31, segment identifier in bits 30:7, secondary flag in bit 6, abbreviated page index in bits 5:0. An entry matches when valid is 1, the flag equals the current pass (0 primary, 1 secondary), the identifier equals vsid_in and the page index equals E[27:22].
- R6: The first matching entry ends the walk with hit = 1: real_addr = {word 1 bits 31:12, E[11:0]}, wimg = word 1 bits 6:3 and prot = word 1 bits 1:0 (word 1 is mem_data[31:0]). No later entry is read.
- R7: After eight primary misses the engine searches the group given by R3 with N replaced by its bitwise complement, accepting only entries whose secondary flag is 1.
- R8: When all sixteen entries miss, the walk ends with fault = 1 and hit = 0 after exactly sixteen reads.
- R9: start is taken only while busy is 0. busy stays high from the cycle after start until the one-cycle done pulse; hit, fault and the result outputs are valid at done and hold until the next start. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Write strobe for the table configuration register |
| cfg_data | input | 32 | Table base (31:16) and hash mask (8:0) |
| start | input | 1 | Begin a walk with vsid_in and ea_in |
| vsid_in | input | 24 | Segment identifier of the access |
| ea_in | input | 32 | Effective address of the access |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| hit | output | 1 | Last walk found an entry |
| fault | output | 1 | Last walk missed in both groups |
| real_addr | output | 32 | Translated address |
| wimg | output | 4 | Storage-control bits of the matching entry |
| prot | output | 2 | Protection bits of the matching entry |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_valid | input | 1 | Read data present on mem_data |
| mem_data | input | 64 | Entry read from memory |

## Verification
The assertions watch on every cycle that reads are 8-byte aligned, stay inside the configured table, never overlap and only occur while busy, that done is a single-cycle pulse ending every busy period with exactly one of hit and fault, that a fault follows exactly sixteen reads, and that the real address keeps the page offset. What only the bench scenarios can show is the hash and mask arithmetic of the group address, the strict read order, the rejection of near-miss entries (invalid, wrong pass flag, wrong identifier, wrong page index), the switch to the complemented group, and that starts and configuration writes issued during a walk leave it and the next walk untouched.

// File: rtl/hpt_pkg.sv
// Shared constants, types and the entry decoder for the hashed page table
// walker. Bit positions follow the LSB-0 convention of the brief.
package hpt_pkg;

    localparam int VSID_W     = 24;
    localparam int ADDR_W     = 32;
    localparam int HASH_W     = 19;
    localparam int PIDX_W     = 16;
    localparam int MASK_W     = 9;
    localparam int BASE_W     = 16;
    localparam int RPN_W      = 20;
    localparam int API_W      = 6;
    localparam int OFS_W      = 12;
    localparam int ENTRY_W    = 64;
    localparam int ENTRY_SHIFT = 3;   // 8-byte entries
    localparam int GROUP_SHIFT = 6;   // 64-byte groups

    // Decoded page table entry.
    typedef struct packed {
        logic              valid;
        logic [VSID_W-1:0] vsid;
        logic              sec;
        logic [API_W-1:0]  api;
        logic [RPN_W-1:0]  rpn;
        logic              refd;
        logic              chg;
        logic [3:0]        wimg;
        logic [1:0]        pp;
    } hpt_entry_t;

    // Walk controller states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;

    // Split a raw 64-bit entry into its fields (word 0 in the upper half).
    function automatic hpt_entry_t decode_entry(input logic [ENTRY_W-1:0] raw);
        hpt_entry_t e;
        e.valid = raw[63];
        e.vsid  = raw[62:39];
        e.sec   = raw[38];
        e.api   = raw[37:32];
        e.rpn   = raw[31:12];
        e.refd  = raw[8];
        e.chg   = raw[7];
        e.wimg  = raw[6:3];
        e.pp    = raw[1:0];
        return e;
    endfunction

endpackage

// File: rtl/hpt_hash.sv
// Group address generator.
// Computes the primary or (when secondary_i is set) complemented hash of the
// segment identifier and page index, and folds it into the table base under
// the hash mask. Purely combinational. Assumes software keeps base bits that
// overlap set mask bits at zero (table aligned to its size).
module hpt_hash
    import hpt_pkg::*;
(
    input  logic [HASH_W-1:0] vsid_lo_i,
    input  logic [PIDX_W-1:0] page_idx_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              secondary_i,
    output logic [ADDR_W-1:0] group_addr_o
);

    localparam int LOW_W  = HASH_W - MASK_W;          // hash bits used unmasked
    localparam int TOP_W  = BASE_W - MASK_W;          // base bits passed through
    localparam int PAD_W  = HASH_W - PIDX_W;

    logic [HASH_W-1:0] raw_hash;
    logic [HASH_W-1:0] hash_sel;
    logic [MASK_W-1:0] mid_bits;

    // Form the XOR hash and pick the pass variant.
    always_comb begin
        raw_hash = vsid_lo_i ^ {{PAD_W{1'b0}}, page_idx_i};
        hash_sel = secondary_i ? ~raw_hash : raw_hash;
    end

    // Merge the masked upper hash bits with the base and build the address.
    always_comb begin
        mid_bits     = (hash_sel[HASH_W-1:LOW_W] & mask_i) | base_i[MASK_W-1:0];
        group_addr_o = {base_i[BASE_W-1:BASE_W-TOP_W], mid_bits,
                        hash_sel[LOW_W-1:0], {GROUP_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/hpt_entry_cmp.sv
// Entry comparator.
// Decodes one entry read from memory and decides whether it translates the
// current page in the current pass. Also presents the result fields.
// Purely combinational; the caller qualifies hit_o with read-data valid.
module hpt_entry_cmp
    import hpt_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic [VSID_W-1:0]  vsid_i,
    input  logic [API_W-1:0]   api_i,
    input  logic               secondary_i,
    output logic               hit_o,
    output logic [RPN_W-1:0]   rpn_o,
    output logic [3:0]         wimg_o,
    output logic [1:0]         pp_o
);

    hpt_entry_t ent;
    logic       tag_ok;
    logic       unused_entry_bits;

    // Decode the raw entry.
    always_comb ent = decode_entry(entry_i);

    // Match valid, pass flag, segment identifier and abbreviated page index.
    always_comb begin
        tag_ok = (ent.vsid == vsid_i) && (ent.api == api_i);
        hit_o  = ent.valid && (ent.sec == secondary_i) && tag_ok;
    end

    // Pass the translation fields through.
    always_comb begin
        rpn_o  = ent.rpn;
        wimg_o = ent.wimg;
        pp_o   = ent.pp;
    end

    // Fields that this engine reads but does not act on.
    assign unused_entry_bits = ^{ent.refd, ent.chg, entry_i[11:9], entry_i[2]};

endmodule

// File: rtl/hpt_walk_ctrl.sv
// Walk controller.
// Sequences one translation: issues a one-cycle read per entry, waits for the
// data, steps through the group, switches to the secondary pass after the
// last primary entry and ends with a one-cycle done. Accepts start only when
// idle. Assumes the memory answers each request exactly once, later.
module hpt_walk_ctrl
    import hpt_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8,
    localparam int IDX_W = $clog2(GROUP_ENTRIES)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mem_valid_i,
    input  logic             entry_hit_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             mem_req_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             secondary_o,
    output logic             load_o,
    output logic             cap_hit_o,
    output logic             cap_fault_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

    walk_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic             sec_q;
    logic             last_entry;
    logic             data_in;

    // Decode events of the current cycle.
    always_comb begin
        last_entry  = (idx_q == LAST_IDX);
        data_in     = (state_q == ST_WAIT) && mem_valid_i;
        load_o      = (state_q == ST_IDLE) && start_i;
        cap_hit_o   = data_in && entry_hit_i;
        cap_fault_o = data_in && !entry_hit_i && last_entry && sec_q;
    end

    // State, entry index and pass registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            sec_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_ISSUE;
                        idx_q   <= '0;
                        sec_q   <= 1'b0;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_valid_i) begin
                        if (entry_hit_i) begin
                            state_q <= ST_DONE;
                        end else if (!last_entry) begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end else if (!sec_q) begin
                            sec_q   <= 1'b1;
                            idx_q   <= '0;
                            state_q <= ST_ISSUE;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the status and request outputs from the state.
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        mem_req_o   = (state_q == ST_ISSUE);
        idx_o       = idx_q;
        secondary_o = sec_q;
    end

endmodule

// File: rtl/hpt_walker.sv
// Hashed page table search engine (top).
// Holds the table configuration register and the request being translated,
// drives the group address generator and entry comparator from the walk
// controller, and keeps the result of the last walk. Assumes a memory port
// that returns one 64-bit entry per request with any latency.
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8,
    localparam int IDX_W = $clog2(GROUP_ENTRIES)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [31:0]        cfg_data,
    input  logic               start,
    input  logic [VSID_W-1:0]  vsid_in,
    input  logic [ADDR_W-1:0]  ea_in,
    output logic               busy,
    output logic               done,
    output logic               hit,
    output logic               fault,
    output logic [ADDR_W-1:0]  real_addr,
    output logic [3:0]         wimg,
    output logic [1:0]         prot,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_valid,
    input  logic [ENTRY_W-1:0] mem_data
);

    logic [BASE_W-1:0] cfg_base_q;
    logic [MASK_W-1:0] cfg_mask_q;
    logic [VSID_W-1:0] vsid_q;
    logic [ADDR_W-1:0] ea_q;

    logic              hit_q, fault_q;
    logic [ADDR_W-1:0] ra_q;
    logic [3:0]        wimg_q;
    logic [1:0]        prot_q;

    logic [IDX_W-1:0]  idx;
    logic              secondary;
    logic              load, cap_hit, cap_fault;
    logic              entry_hit;
    logic [RPN_W-1:0]  ent_rpn;
    logic [3:0]        ent_wimg;
    logic [1:0]        ent_pp;
    logic [ADDR_W-1:0] group_addr;
    logic              unused_top_bits;

    // Configuration register; writes are blocked during a walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_base_q <= '0;
            cfg_mask_q <= '0;
        end else if (cfg_load && !busy) begin
            cfg_base_q <= cfg_data[31:16];
            cfg_mask_q <= cfg_data[MASK_W-1:0];
        end
    end

    // Capture the request when a walk begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsid_q <= '0;
            ea_q   <= '0;
        end else if (load) begin
            vsid_q <= vsid_in;
            ea_q   <= ea_in;
        end
    end

    // Result registers: cleared at start, set by the terminating event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            fault_q <= 1'b0;
            ra_q    <= '0;
            wimg_q  <= '0;
            prot_q  <= '0;
        end else if (load) begin
            hit_q   <= 1'b0;
            fault_q <= 1'b0;
            ra_q    <= '0;
            wimg_q  <= '0;
            prot_q  <= '0;
        end else if (cap_hit) begin
            hit_q   <= 1'b1;
            ra_q    <= {ent_rpn, ea_q[OFS_W-1:0]};
            wimg_q  <= ent_wimg;
            prot_q  <= ent_pp;
        end else if (cap_fault) begin
            fault_q <= 1'b1;
        end
    end

    hpt_walk_ctrl #(.GROUP_ENTRIES(GROUP_ENTRIES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .mem_valid_i (mem_valid),
        .entry_hit_i (entry_hit),
        .busy_o      (busy),
        .done_o      (done),
        .mem_req_o   (mem_req),
        .idx_o       (idx),
        .secondary_o (secondary),
        .load_o      (load),
        .cap_hit_o   (cap_hit),
        .cap_fault_o (cap_fault)
    );

    hpt_hash u_hash (
        .vsid_lo_i    (vsid_q[HASH_W-1:0]),
        .page_idx_i   (ea_q[OFS_W+PIDX_W-1:OFS_W]),
        .base_i       (cfg_base_q),
        .mask_i       (cfg_mask_q),
        .secondary_i  (secondary),
        .group_addr_o (group_addr)
    );

    hpt_entry_cmp u_cmp (
        .entry_i     (mem_data),
        .vsid_i      (vsid_q),
        .api_i       (ea_q[OFS_W+PIDX_W-1:OFS_W+PIDX_W-API_W]),
        .secondary_i (secondary),
        .hit_o       (entry_hit),
        .rpn_o       (ent_rpn),
        .wimg_o      (ent_wimg),
        .pp_o        (ent_pp)
    );

    // Entry address inside the selected group.
    always_comb mem_addr = group_addr + (ADDR_W'(idx) << ENTRY_SHIFT);

    // Result outputs.
    always_comb begin
        hit       = hit_q;
        fault     = fault_q;
        real_addr = ra_q;
        wimg      = wimg_q;
        prot      = prot_q;
    end

    // Reserved configuration bits and address bits above the page index.
    assign unused_top_bits = ^{cfg_data[15:MASK_W], ea_q[ADDR_W-1:OFS_W+PIDX_W]};

endmodule

// File: rtl/hpt_walker_chk.sv
// Protocol and outcome checker for hpt_walker, bound into every instance.
// Tracks outstanding reads and reads per walk with its own counters.
module hpt_walker_chk #(
    parameter int GROUP_ENTRIES = 8
)(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        hit,
    input logic        fault,
    input logic        mem_req,
    input logic        mem_valid,
    input logic [31:0] mem_addr,
    input logic [31:0] real_addr,
    input logic [6:0]  table_top,
    input logic [11:0] ea_ofs
);

    localparam int MAX_READS = 2 * GROUP_ENTRIES;

    logic       outstanding_q;
    logic [7:0] reads_q;

    // Track whether a read awaits its data.
    always_ff @(posedge clk) begin
        if (!rst_n)         outstanding_q <= 1'b0;
        else if (mem_req)   outstanding_q <= 1'b1;
        else if (mem_valid) outstanding_q <= 1'b0;
    end

    // Count reads issued in the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n)               reads_q <= '0;
        else if (start && !busy)  reads_q <= '0;
        else if (mem_req)         reads_q <= reads_q + 8'd1;
    end

    assert_req_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outstanding_q);

    assert_req_in_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[31:25] == table_top));

    assert_req_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ends_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hit != fault));

    assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (real_addr[11:0] == ea_ofs));

    assert_read_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reads_q <= 8'(MAX_READS));

    assert_fault_full_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (reads_q == 8'(MAX_READS)));

endmodule

bind hpt_walker hpt_walker_chk #(.GROUP_ENTRIES(GROUP_ENTRIES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .hit       (hit),
    .fault     (fault),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .real_addr (real_addr),
    .table_top (cfg_base_q[15:9]),
    .ea_ofs    (ea_q[11:0])
);

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        start = 1'b0;
    logic [23:0] vsid_in = '0;
    logic [31:0] ea_in = '0;
    logic        busy, done, hit, fault, mem_req;
    logic [31:0] real_addr, mem_addr;
    logic [3:0]  wimg;
    logic [1:0]  prot;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_data = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    int mem_lat = 0;

    logic [63:0] mem [int unsigned];
    logic [31:0] addr_log [$];

    hpt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data),
        .start(start), .vsid_in(vsid_in), .ea_in(ea_in),
        .busy(busy), .done(done), .hit(hit), .fault(fault),
        .real_addr(real_addr), .wimg(wimg), .prot(prot),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Memory model: answers each request mem_lat+1 cycles later.
    initial begin
        forever begin
            @(negedge clk);
            mem_valid = 1'b0;
            if (mem_req) begin
                logic [31:0] a;
                a = mem_addr;
                addr_log.push_back(a);
                repeat (mem_lat + 1) @(negedge clk);
                mem_data  = mem.exists(a) ? mem[a] : 64'h0;
                mem_valid = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_group(input logic [23:0] v, input logic [31:0] ea,
                                              input logic [31:0] cfg, input bit sec);
        logic [18:0] n;
        logic [8:0]  mid;
        n = v[18:0] ^ {3'b000, ea[27:12]};
        if (sec) n = ~n;
        mid = (n[18:10] & cfg[8:0]) | cfg[24:16];
        return {cfg[31:25], mid, n[9:0], 6'b000000};
    endfunction

    function automatic logic [63:0] mk_entry(input bit v, input logic [23:0] vs, input bit h,
                                             input logic [5:0] api, input logic [19:0] rpn,
                                             input logic [3:0] wg, input logic [1:0] pp);
        return {v, vs, h, api, rpn, 3'b000, 1'b0, 1'b0, wg, 1'b0, pp};
    endfunction

    task automatic load_cfg(input logic [31:0] c);
        @(negedge clk);
        cfg_data = c; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Start a walk and wait for done; leaves the bench at the done cycle.
    task automatic run_search(input logic [23:0] v, input logic [31:0] ea);
        int t;
        addr_log.delete();
        @(negedge clk);
        vsid_in = v; ea_in = ea; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 2000) begin @(negedge clk); t++; end
        chk("R9", "done seen", {63'b0, done}, 64'h1);
    endtask

    task automatic t_reset();
        chk("R1", "busy", {63'b0, busy}, 64'h0);
        chk("R1", "done", {63'b0, done}, 64'h0);
        chk("R1", "hit/fault", {62'b0, hit, fault}, 64'h0);
        chk("R1", "mem_req", {63'b0, mem_req}, 64'h0);
        chk("R1", "real_addr", {32'b0, real_addr}, 64'h0);
        chk("R1", "wimg/prot", {58'b0, wimg, prot}, 64'h0);
        // Cleared config: first read of a walk lands at the unmasked hash.
        mem_lat = 0; mem.delete();
        run_search(24'h000001, 32'h0000_0000);
        chk("R1", "zero config address", {32'b0, addr_log[0]},
            {32'b0, exp_group(24'h000001, 32'h0, 32'h0, 1'b0)});
    endtask

    task automatic t_primary_first();
        logic [31:0] cfg, g;
        cfg = 32'h0010_0000;
        load_cfg(cfg);
        mem.delete(); mem_lat = 0;
        g = exp_group(24'h123456, 32'h0ABC_D123, cfg, 1'b0);
        mem[g] = mk_entry(1, 24'h123456, 0, 6'h2A, 20'hABCDE, 4'h5, 2'b10);
        run_search(24'h123456, 32'h0ABC_D123);
        chk("R3", "primary group address", {32'b0, addr_log[0]}, {32'b0, g});
        chk("R6", "hit", {62'b0, hit, fault}, 64'h2);
        chk("R6", "real_addr", {32'b0, real_addr}, 64'hABCD_E123);
        chk("R6", "wimg/prot", {58'b0, wimg, prot}, {58'b0, 4'h5, 2'b10});
        chk("R6", "single read", 64'(addr_log.size()), 64'd1);
        @(negedge clk); @(negedge clk);
        chk("R9", "result held, busy low", {31'b0, busy, real_addr}, 64'hABCD_E123);
    endtask

    task automatic t_order_latency();
        logic [31:0] cfg, g, ea;
        logic [23:0] v;
        logic [5:0]  api;
        bit ok;
        cfg = 32'h0010_0000; v = 24'h00ABCD; ea = 32'h1234_5FFF;
        api = ea[27:22];
        mem.delete(); mem_lat = 3;
        g = exp_group(v, ea, cfg, 1'b0);
        mem[g + 0]  = mk_entry(0, v, 0, api, 20'h11111, 4'h1, 2'b01);          // invalid
        mem[g + 8]  = mk_entry(1, v, 1, api, 20'h22222, 4'h2, 2'b01);          // wrong pass
        mem[g + 16] = mk_entry(1, v ^ 24'h800000, 0, api, 20'h33333, 4'h3, 2'b01); // wrong id
        mem[g + 24] = mk_entry(1, v, 0, api ^ 6'h01, 20'h44444, 4'h4, 2'b01);  // wrong api
        mem[g + 32] = mk_entry(1, v, 0, api, 20'h55555, 4'hA, 2'b11);          // match
        mem[g + 40] = mk_entry(1, v, 0, api, 20'h66666, 4'hB, 2'b00);          // later match
        run_search(v, ea);
        chk("R5", "near misses skipped", {32'b0, real_addr}, 64'h5555_5FFF);
        chk("R6", "first match wins", {58'b0, wimg, prot}, {58'b0, 4'hA, 2'b11});
        chk("R6", "reads stop at match", 64'(addr_log.size()), 64'd5);
        ok = 1;
        foreach (addr_log[i]) if (addr_log[i] !== g + 32'(8 * i)) ok = 0;
        chk("R4", "read order and stride", {63'b0, ok}, 64'h1);
    endtask

    task automatic t_mask();
        logic [31:0] cfg, g;
        cfg = 32'h0200_01FF;
        load_cfg(cfg);
        mem.delete(); mem_lat = 1;
        g = exp_group(24'h7FFFF0, 32'h0F00_0000, cfg, 1'b0);
        mem[g] = mk_entry(1, 24'h7FFFF0, 0, 6'h3C, 20'h00F00, 4'h0, 2'b01);
        run_search(24'h7FFFF0, 32'h0F00_0000);
        chk("R3", "masked group address", {32'b0, addr_log[0]}, {32'b0, g});
        chk("R2", "config applied", {32'b0, addr_log[0]}, 64'h03C3_FC00);
        chk("R6", "masked hit", {32'b0, real_addr}, 64'h00F0_0000);
    endtask

    task automatic t_secondary();
        logic [31:0] cfg, g1, g2, ea;
        logic [23:0] v;
        cfg = 32'h0010_0000; v = 24'h000777; ea = 32'h0555_5ABC;
        load_cfg(cfg);
        mem.delete(); mem_lat = 0;
        g1 = exp_group(v, ea, cfg, 1'b0);
        g2 = exp_group(v, ea, cfg, 1'b1);
        mem[g2 + 8]  = mk_entry(1, v, 0, ea[27:22], 20'h0BAD0, 4'h1, 2'b01); // primary-tagged
        mem[g2 + 16] = mk_entry(1, v, 1, ea[27:22], 20'h600D0, 4'hC, 2'b10);
        run_search(v, ea);
        chk("R7", "primary group first", {32'b0, addr_log[0]}, {32'b0, g1});
        chk("R7", "secondary group address", {32'b0, addr_log[8]}, {32'b0, g2});
        chk("R7", "secondary hit", {32'b0, real_addr}, 64'h600D_0ABC);
        chk("R7", "read count", 64'(addr_log.size()), 64'd11);
    endtask

    task automatic t_fault();
        logic [31:0] cfg, g2;
        cfg = 32'h0010_0000;
        mem.delete(); mem_lat = 2;
        g2 = exp_group(24'h0F0F0F, 32'h0333_3000, cfg, 1'b1);
        run_search(24'h0F0F0F, 32'h0333_3000);
        chk("R8", "fault flags", {62'b0, hit, fault}, 64'h1);
        chk("R8", "sixteen reads", 64'(addr_log.size()), 64'd16);
        chk("R8", "last read", {32'b0, addr_log[addr_log.size()-1]}, {32'b0, g2 + 32'd56});
    endtask

    task automatic t_busy_ignore();
        logic [31:0] cfg, g;
        logic [23:0] v;
        logic [31:0] ea;
        int t;
        cfg = 32'h0010_0000; v = 24'h424242; ea = 32'h0777_7444;
        mem.delete(); mem_lat = 4;
        g = exp_group(v, ea, cfg, 1'b0);
        mem[g + 8] = mk_entry(1, v, 0, ea[27:22], 20'h12345, 4'h7, 2'b01);
        addr_log.delete();
        @(negedge clk);
        vsid_in = v; ea_in = ea; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "busy during walk", {63'b0, busy}, 64'h1);
        vsid_in = 24'h111111; ea_in = 32'h0222_2000; start = 1'b1;
        cfg_data = 32'h0F00_0000; cfg_load = 1'b1;
        @(negedge clk);
        start = 1'b0; cfg_load = 1'b0;
        t = 0;
        while (!done && t < 2000) begin @(negedge clk); t++; end
        chk("R9", "first walk result", {32'b0, real_addr}, 64'h1234_5444);
        chk("R9", "reads of first walk", 64'(addr_log.size()), 64'd2);
        repeat (10) @(negedge clk);
        chk("R9", "ignored start left no walk", {62'b0, busy, mem_req}, 64'h0);
        chk("R9", "no extra reads", 64'(addr_log.size()), 64'd2);
        run_search(v, ea);
        chk("R2", "config write while busy ignored", {32'b0, addr_log[0]}, {32'b0, g});
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_primary_first();
        t_order_latency();
        t_mask();
        t_secondary();
        t_fault();
        t_busy_ignore();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule